// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a 32-bit tick counter with a mode register, reached through a simple register write/read port. Software picks one of four operating modes in the mode register: off, wrap-to-zero on match, halt on match, or free-run past a match. It also sets a period there, against which the low bits of the counter are compared every cycle.

A match can raise a sticky interrupt-pending flag, if the interrupt-enable bit is set. The block drives a tick-exception request whenever that flag is set and an external exception-enable input is high. The exception vectoring and the processor pipeline that consume the request lie outside the block.

Top module: `tick_timer`

## Requirements
- R1: Register select 0 addresses the count register and select 1 addresses the mode register. The mode register layout is mode in bits 31:30, interrupt enable in bit 29, pending in bit 28 and period in bits 27:0. Read data always shows the selected register's present value.
- R2: In mode 0 (off) the count register keeps its value, unless software writes it.
- R3: In mode 3 (free-run) the count increments by one every cycle, runs through a match without pausing and wraps from all-ones to zero.
- R4: In mode 1 (wrap), when the count's low 28 bits equal the period, the count becomes zero on the next edge and then counts up again.
- R5: In mode 2 (halt), once the count matches the period it holds that value. It stays held until the count or the mode register is written, and after such a write it counts on.
- R6: A match in any mode other than 0 sets the pending bit when the interrupt-enable bit is 1. With interrupt enable at 0, a match leaves the pending bit alone.
- R7: The pending bit stays set until a mode-register write carries a 0 in bit 28. If a match with interrupt enable set falls in the same cycle as that write, the pending bit stays set.
- R8: The tick request output is high exactly when the pending bit is 1 and the exception-enable input is 1.
- R9: A mode-register write whose mode field is 1 clears the count register on that edge.
- R10: A count-register write loads the written value on that edge, taking priority over increment, wrap and halt. Counting then continues from the loaded value.
- R11: Reset clears both the count register and the mode register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 count, 1 mode |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| exc_en | input | 1 | External tick exception enable |
| tick_req | output | 1 | Tick exception request |

## Verification
The bench goes after these corner cases:
- **Halted match cleared in the same cycle.** Software tries to clear the pending bit while the counter sits halted on a match with interrupt enable set. A design that lets the clear win would drop a pending interrupt.
- **Counter sitting on the match value.** The bench watches the counter through a halt and checks that a count write releases it. A design that ignored the halt would run past the period. One that latched the halt would never resume.
- **Mode-1 writes and the wrap point.** The bench checks that a mode-1 write zeroes the counter at once, and that a match in wrap mode returns it to zero. Getting either wrong shows up as a count offset by one or by the period.
- **Pending without interrupt enable.** A match with interrupt enable clear must not raise pending.
- **All-ones rollover.** The counter must wrap from all-ones to zero.

// File: rtl/tick_pkg.sv
package tick_pkg;
   typedef enum logic [1:0] {
      TM_OFF  = 2'd0,
      TM_WRAP = 2'd1,
      TM_HALT = 2'd2,
      TM_FREE = 2'd3
   } tick_mode_e;
endpackage

// File: rtl/tick_match.sv
module tick_match #(
   parameter int PERIOD_W = 28,
   parameter int SLICE_W  = 7
) (
   input  logic [PERIOD_W-1:0] cnt_low,
   input  logic [PERIOD_W-1:0] period,
   input  logic                active,
   output logic                hit
);
   localparam int NSLICE = PERIOD_W / SLICE_W;

   initial begin
      if (PERIOD_W % SLICE_W != 0)
         $error("tick_match: PERIOD_W must be a multiple of SLICE_W");
   end

   logic [NSLICE-1:0] slice_eq;

   for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      assign slice_eq[s] = (cnt_low[s*SLICE_W +: SLICE_W] == period[s*SLICE_W +: SLICE_W]);
   end

   assign hit = active && (&slice_eq);
endmodule

// File: rtl/tick_ctrl_reg.sv
module tick_ctrl_reg #(
   parameter int CNT_W    = 32,
   parameter int PERIOD_W = 28
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [CNT_W-1:0]    wdata,
   input  logic                hit,
   output logic [CNT_W-1:0]    ctrl_q,
   output tick_pkg::tick_mode_e mode,
   output logic                ie,
   output logic                pending,
   output logic [PERIOD_W-1:0] period
);
   localparam int PEND_BIT = PERIOD_W;
   localparam int IE_BIT   = PERIOD_W + 1;
   localparam int MODE_LO  = PERIOD_W + 2;

   logic            set_pend;
   logic [CNT_W-1:0] ctrl_d;

   assign mode     = tick_pkg::tick_mode_e'(ctrl_q[MODE_LO +: 2]);
   assign ie       = ctrl_q[IE_BIT];
   assign pending  = ctrl_q[PEND_BIT];
   assign period   = ctrl_q[PERIOD_W-1:0];
   assign set_pend = hit && ie;

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr) ctrl_d = wdata;
      if (set_pend) ctrl_d[PEND_BIT] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end

   // R6: an enabled match raises pending on the next edge
   assert_match_sets_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ie) |=> pending);

   // R6: a match with enable clear never raises pending by itself
   assert_no_pend_without_ie_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && !ie && !wr) |=> !pending);

   // R7: pending is sticky unless a write clears it
   assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !(wr && !wdata[PEND_BIT])) |=> pending);
endmodule

// File: rtl/tick_count.sv
module tick_count #(
   parameter int CNT_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_cnt,
   input  logic                 wr_mode,
   input  logic [CNT_W-1:0]     wdata,
   input  tick_pkg::tick_mode_e new_mode,
   input  tick_pkg::tick_mode_e mode,
   input  logic                 hit,
   output logic [CNT_W-1:0]     cnt_q
);
   import tick_pkg::*;

   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (wr_cnt)                                cnt_d = wdata;
      else if (wr_mode && new_mode == TM_WRAP)   cnt_d = '0;
      else if (mode == TM_OFF)                   cnt_d = cnt_q;
      else if (hit && mode == TM_WRAP)           cnt_d = '0;
      else if (hit && mode == TM_HALT && !wr_mode) cnt_d = cnt_q;
      else                                       cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   // R2: off mode holds the count when nothing is written
   assert_off_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_OFF && !wr_cnt && !wr_mode) |=> $stable(cnt_q));

   // R4: wrap mode returns to zero after a match
   assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode == TM_WRAP && !wr_cnt) |=> (cnt_q == '0));

   // R5: halt mode freezes on a match
   assert_halt_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode == TM_HALT && !wr_cnt && !wr_mode) |=> $stable(cnt_q));

   // R9: a mode write selecting wrap clears the count
   assert_wrap_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && new_mode == TM_WRAP) |=> (cnt_q == '0));

   // R10: a count write loads the data
   assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (cnt_q == $past(wdata)));

   // R3: free-run steps by one when not written
   assert_free_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_FREE && !wr_cnt && !wr_mode) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
   parameter int CNT_W    = 32,
   parameter int PERIOD_W = 28,
   parameter int SLICE_W  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic             reg_sel,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   input  logic             exc_en,
   output logic             tick_req
);
   import tick_pkg::*;

   localparam int MODE_LO = PERIOD_W + 2;

   initial begin
      if (CNT_W != PERIOD_W + 4)
         $error("tick_timer: CNT_W must equal PERIOD_W + 4");
   end

   logic                wr_cnt, wr_mode, hit, ie, pending;
   logic [CNT_W-1:0]    cnt_q, ctrl_q;
   logic [PERIOD_W-1:0] period;
   tick_mode_e          mode, new_mode;

   assign wr_cnt   = reg_we && !reg_sel;
   assign wr_mode  = reg_we &&  reg_sel;
   assign new_mode = tick_mode_e'(reg_wdata[MODE_LO +: 2]);

   tick_match #(.PERIOD_W(PERIOD_W), .SLICE_W(SLICE_W)) u_match (
      .cnt_low (cnt_q[PERIOD_W-1:0]),
      .period  (period),
      .active  (mode != TM_OFF),
      .hit     (hit)
   );

   tick_ctrl_reg #(.CNT_W(CNT_W), .PERIOD_W(PERIOD_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_mode),
      .wdata   (reg_wdata),
      .hit     (hit),
      .ctrl_q  (ctrl_q),
      .mode    (mode),
      .ie      (ie),
      .pending (pending),
      .period  (period)
   );

   tick_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cnt   (wr_cnt),
      .wr_mode  (wr_mode),
      .wdata    (reg_wdata),
      .new_mode (new_mode),
      .mode     (mode),
      .hit      (hit),
      .cnt_q    (cnt_q)
   );

   assign reg_rdata = reg_sel ? ctrl_q : cnt_q;
   assign tick_req  = pending && exc_en;

   // R8: the request is never raised while the external enable is low
   assert_req_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_en |-> !tick_req);

   // R1: a mode write reads back its period field on the next cycle
   assert_period_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mode |=> (period == $past(reg_wdata[PERIOD_W-1:0])));
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        exc_en = 1'b0;
   logic        tick_req;

   int total = 0;
   int bad = 0;
   logic [31:0] m_cnt = '0;
   logic [31:0] m_mode = '0;

   always #4 clk = ~clk;

   tick_timer u_tick_timer (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .exc_en(exc_en), .tick_req(tick_req)
   );

   // Behavioural reference, updated at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt  = 0;
         m_mode = 0;
      end else begin
         int  md;
         bit  match, setp, wc, wm;
         md    = int'(m_mode[31:30]);
         match = (md != 0) && (m_cnt[27:0] == m_mode[27:0]);
         setp  = match && m_mode[29];
         wc    = reg_we && !reg_sel;
         wm    = reg_we && reg_sel;
         if (wc) m_cnt = reg_wdata;
         else if (wm && reg_wdata[31:30] == 2'd1) m_cnt = 0;
         else if (md == 0) m_cnt = m_cnt;
         else if (match && md == 1) m_cnt = 0;
         else if (match && md == 2 && !wm) m_cnt = m_cnt;
         else m_cnt = m_cnt + 1;
         if (wm) m_mode = reg_wdata;
         if (setp) m_mode[28] = 1'b1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_reg(input bit sel, output logic [31:0] v);
      reg_sel = sel;
      #1 v = reg_rdata;
   endtask

   // One clock, then compare both registers and the request with the model
   task automatic tick();
      logic [31:0] v;
      @(posedge clk);
      #2;
      reg_we = 1'b0;
      read_reg(1'b0, v);
      check("R1 count vs model", v, m_cnt);
      read_reg(1'b1, v);
      check("R1 mode vs model", v, m_mode);
      check("R8 request vs model", {31'b0, tick_req}, {31'b0, m_mode[28] & exc_en});
   endtask

   task automatic wr(input bit sel, input logic [31:0] d);
      reg_sel = sel;
      reg_wdata = d;
      reg_we = 1'b1;
      tick();
   endtask

   function automatic logic [31:0] mreg(input int md, input bit ie, input bit pd, input int per);
      return {md[1:0], ie, pd, per[27:0]};
   endfunction

   initial begin
      logic [31:0] v;
      fork
         begin
            repeat (3) tick();
            read_reg(1'b0, v); check("R11 count after reset", v, 32'h0);
            read_reg(1'b1, v); check("R11 mode after reset", v, 32'h0);
            check("R8 request after reset", {31'b0, tick_req}, 32'h0);
            rst_n = 1'b1;
            tick();

            wr(1'b0, 32'd5);
            read_reg(1'b0, v); check("R10 count load", v, 32'd5);
            repeat (3) tick();
            read_reg(1'b0, v); check("R2 off mode holds", v, 32'd5);

            wr(1'b1, mreg(3, 1'b1, 1'b0, 8));
            read_reg(1'b0, v); check("R2 write cycle in off mode", v, 32'd5);
            repeat (6) tick();
            read_reg(1'b0, v); check("R3 free run past match", v, 32'd11);
            read_reg(1'b1, v); check("R6 pending set on match", {31'b0, v[28]}, 32'h1);
            check("R8 request low with enable low", {31'b0, tick_req}, 32'h0);
            exc_en = 1'b1;
            #1 check("R8 request high with enable", {31'b0, tick_req}, 32'h1);

            wr(1'b1, mreg(3, 1'b1, 1'b0, 8));
            read_reg(1'b1, v); check("R7 pending cleared by write", {31'b0, v[28]}, 32'h0);
            check("R8 request drops", {31'b0, tick_req}, 32'h0);

            wr(1'b1, mreg(1, 1'b0, 1'b0, 3));
            read_reg(1'b0, v); check("R9 mode-1 write clears", v, 32'h0);
            repeat (3) tick();
            read_reg(1'b0, v); check("R4 reaches period", v, 32'd3);
            tick();
            read_reg(1'b0, v); check("R4 wraps to zero", v, 32'd0);
            read_reg(1'b1, v); check("R6 no pending without enable", {31'b0, v[28]}, 32'h0);

            wr(1'b0, 32'd0);
            wr(1'b1, mreg(2, 1'b1, 1'b0, 4));
            repeat (6) tick();
            read_reg(1'b0, v); check("R5 halted at period", v, 32'd4);
            read_reg(1'b1, v); check("R6 pending in halt mode", {31'b0, v[28]}, 32'h1);

            wr(1'b1, mreg(2, 1'b1, 1'b0, 4));
            read_reg(1'b1, v); check("R7 match wins over clear", {31'b0, v[28]}, 32'h1);
            read_reg(1'b0, v); check("R5 mode write releases halt", v, 32'd5);

            wr(1'b0, 32'd4);
            repeat (2) tick();
            read_reg(1'b0, v); check("R5 halted again after load", v, 32'd4);
            wr(1'b0, 32'd20);
            tick();
            read_reg(1'b0, v); check("R10 load releases and counts on", v, 32'd21);

            wr(1'b1, mreg(3, 1'b0, 1'b0, 32'h0FFF_FFFF));
            wr(1'b0, 32'hFFFF_FFFE);
            repeat (3) tick();
            read_reg(1'b0, v); check("R3 wraps through all-ones", v, 32'd1);

            rst_n = 1'b0;
            repeat (2) tick();
            read_reg(1'b0, v); check("R11 count after mid-run reset", v, 32'h0);
            read_reg(1'b1, v); check("R11 mode after mid-run reset", v, 32'h0);
            rst_n = 1'b1;
            tick();
         end
         begin
            repeat (100000) @(posedge clk);
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule